// File: doc/BRIEF.md
# Clock Output Enable Control Logic

This block decides, for each of the 19 differential pairs of a clock fan-out buffer, whether that pair is driven or held at high impedance. It merges active-low enable pins with per-pair register enable bits. Pairs 0 to 4 share one pin, pairs 16 and 17 share another, and every other pair has a pin of its own. It also resolves the PLL bypass and PLL bandwidth selects, where a low pin or a cleared register bit forces the mode. It holds the two ratio-mode selects: one for the main group of 18 pairs and one for pair 18, geared or 1:1.

All pins are asynchronous and pass through a two-stage synchronizer. A two-state power state machine follows the synchronized power-down pin. In state ST_OFF every pair is tristated and the PLL-on indication is low. In state ST_ON the pair enables apply. The transition WAKE (ST_OFF to ST_ON) is taken when the synchronized power-down pin is high. The transition SLEEP (ST_ON to ST_OFF) is taken when it is low. Reset enters ST_OFF.

The configuration register bits are loaded together by one write strobe. The synchronized enable pins are brought out as live status bits, so that software can read them back.

Top module: `clk_oe_ctrl`

## Requirements
- R1: A pair is driven (`drv_p[i]` = `drv_n[i]` = 1) only when the state is ST_ON, its governing enable pin is low and its register bit `cfg_pair_en[i]` is 1. In every other case both legs are 0, meaning tristate. The two legs of a pair are always equal.
- R2: `oe_grp_lo_n` governs pairs 0 to 4 together, and `oe_grp_hi_n` governs pairs 16 and 17 together. Each of these pairs can still be disabled alone through its own register bit.
- R3: `oe_ind_n[k]` governs pair k+5 alone, for k from 0 to 10. `oe_last_n` governs pair 18 alone.
- R4: `hi_bw` is 1 when the synchronized `bw_pin_n` is 0, or the register bit `cfg_lowbw` is 0, or both. The register bit resets to 1, which means low bandwidth.
- R5: `pll_bypass` is 1 when the synchronized `byp_pin_n` is 0, or the register bit `cfg_pll_sel` is 0, or both. The register bit resets to 1, which means PLL mode.
- R6: While the state is ST_OFF, every pair is tristated and `pll_on` is 0. SLEEP is taken one cycle after the synchronized `pwrdn_n` is seen low, whatever the other enables are. WAKE is taken one cycle after it is seen high.
- R7: On reset, all 19 register enable bits, `cfg_pll_sel`, `cfg_lowbw`, `main_1to1` and `last_1to1` are 1 (ratio selects: 0 = geared, 1 = 1:1). They change only on a clock edge with `cfg_we` = 1.
- R8: `pin_status` reports the synchronized enable pins, 0 for enable and 1 for disable. Bit 0 is `oe_grp_lo_n`, bits 11:1 are `oe_ind_n[10:0]`, bit 12 is `oe_grp_hi_n` and bit 13 is `oe_last_n`. The synchronizer stages reset to 1.
- R9: A pin change sampled at clock edge k reaches the drive, status and mode outputs after edge k+1. A power-down change reaches the state after edge k+2. A register write at edge k takes effect right after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_grp_lo_n | input | 1 | Shared active-low enable, pairs 0-4 |
| oe_ind_n | input | 11 | Dedicated active-low enables, pairs 5-15 |
| oe_grp_hi_n | input | 1 | Shared active-low enable, pairs 16-17 |
| oe_last_n | input | 1 | Dedicated active-low enable, pair 18 |
| pwrdn_n | input | 1 | Active-low power-down |
| bw_pin_n | input | 1 | Low selects high PLL bandwidth |
| byp_pin_n | input | 1 | Low selects PLL bypass |
| cfg_we | input | 1 | Register write strobe |
| cfg_pair_en | input | 19 | Per-pair register enable data |
| cfg_pll_sel_d | input | 1 | PLL-select register data (0 = bypass) |
| cfg_lowbw_d | input | 1 | Bandwidth register data (0 = high) |
| cfg_main_1to1_d | input | 1 | Main-group ratio select data |
| cfg_last_1to1_d | input | 1 | Pair-18 ratio select data |
| drv_p | output | 19 | Drive enable, true legs |
| drv_n | output | 19 | Drive enable, complement legs |
| pll_bypass | output | 1 | PLL bypass select |
| hi_bw | output | 1 | High-bandwidth select |
| pll_on | output | 1 | PLL running indication |
| main_1to1 | output | 1 | Ratio select, pairs 0-17 |
| last_1to1 | output | 1 | Ratio select, pair 18 |
| pin_status | output | 14 | Synchronized enable pin status |

## Verification
The pair gating is first tried with one enable pin raised at a time while all others stay low. This tells the shared pins apart from the dedicated ones, because exactly the pairs mapped to that pin must drop. A single register bit is then cleared inside each shared group, which separates per-pair disable from group disable. The bypass and bandwidth overrides are walked through all four pin and register combinations, which distinguishes OR-of-lows from AND or pass-through behaviour. Power-down is pulsed while every pair is enabled, and long runs of random pin and register traffic expose latency errors against a cycle-level model.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;

    localparam int NUM_PAIRS = 19;
    localparam int NUM_PINS  = 14;
    localparam int LO_GRP_LAST  = 4;
    localparam int IND_LAST     = 15;
    localparam int HI_GRP_LAST  = 17;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_ON  = 1'b1
    } pwr_state_t;

    // Index of the enable pin (in the status vector) governing a pair
    function automatic int pin_of_pair(input int pair);
        if (pair <= LO_GRP_LAST)      return 0;
        else if (pair <= IND_LAST)    return pair - LO_GRP_LAST;
        else if (pair <= HI_GRP_LAST) return IND_LAST - LO_GRP_LAST + 1;
        else                          return IND_LAST - LO_GRP_LAST + 2;
    endfunction

endpackage

// File: rtl/oe_sync_bank.sv
module oe_sync_bank #(
    parameter int WIDTH  = 17,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '1;
        end else begin
            stage_q[0] <= d;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/oe_power_fsm.sv
module oe_power_fsm
    import clk_oe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pdn_n_s,
    output pwr_state_t state
);
    pwr_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (pdn_n_s)  state_nx = ST_ON;   // WAKE
            ST_ON:  if (!pdn_n_s) state_nx = ST_OFF;  // SLEEP
            default: state_nx = ST_OFF;
        endcase
    end

    // R6
    property sleep_follows_pin;
        @(posedge clk) disable iff (!rst_n) !pdn_n_s |=> (state == ST_OFF);
    endproperty
    sleep_entry_chk: assert property (sleep_follows_pin);
endmodule

// File: rtl/oe_pair_gate.sv
module oe_pair_gate
    import clk_oe_pkg::*;
(
    input  logic                 run,
    input  logic [NUM_PINS-1:0]  pin_s,
    input  logic [NUM_PAIRS-1:0] pair_en,
    output logic [NUM_PAIRS-1:0] drv_p,
    output logic [NUM_PAIRS-1:0] drv_n
);
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        localparam int PIN = pin_of_pair(i);
        logic gate;
        assign gate     = run & ~pin_s[PIN] & pair_en[i];
        assign drv_p[i] = gate;
        assign drv_n[i] = gate;
    end
endmodule

// File: rtl/clk_oe_ctrl.sv
module clk_oe_ctrl
    import clk_oe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 oe_grp_lo_n,
    input  logic [10:0]          oe_ind_n,
    input  logic                 oe_grp_hi_n,
    input  logic                 oe_last_n,
    input  logic                 pwrdn_n,
    input  logic                 bw_pin_n,
    input  logic                 byp_pin_n,
    input  logic                 cfg_we,
    input  logic [18:0]          cfg_pair_en,
    input  logic                 cfg_pll_sel_d,
    input  logic                 cfg_lowbw_d,
    input  logic                 cfg_main_1to1_d,
    input  logic                 cfg_last_1to1_d,
    output logic [18:0]          drv_p,
    output logic [18:0]          drv_n,
    output logic                 pll_bypass,
    output logic                 hi_bw,
    output logic                 pll_on,
    output logic                 main_1to1,
    output logic                 last_1to1,
    output logic [13:0]          pin_status
);
    localparam int SYNC_W = NUM_PINS + 3;

    logic [NUM_PAIRS-1:0] en_q;
    logic                 pll_sel_q, lowbw_q;
    logic [SYNC_W-1:0]    sync_d, sync_q;
    logic [NUM_PINS-1:0]  pin_s;
    logic                 pdn_s, bw_s, byp_s, run;
    pwr_state_t           pstate;

    // configuration register bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '1;
            pll_sel_q <= 1'b1;
            lowbw_q   <= 1'b1;
            main_1to1 <= 1'b1;
            last_1to1 <= 1'b1;
        end else if (cfg_we) begin
            en_q      <= cfg_pair_en;
            pll_sel_q <= cfg_pll_sel_d;
            lowbw_q   <= cfg_lowbw_d;
            main_1to1 <= cfg_main_1to1_d;
            last_1to1 <= cfg_last_1to1_d;
        end
    end

    assign sync_d = {byp_pin_n, bw_pin_n, pwrdn_n,
                     oe_last_n, oe_grp_hi_n, oe_ind_n, oe_grp_lo_n};

    oe_sync_bank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sync_d),
        .q     (sync_q)
    );

    assign pin_s = sync_q[NUM_PINS-1:0];
    assign pdn_s = sync_q[NUM_PINS];
    assign bw_s  = sync_q[NUM_PINS+1];
    assign byp_s = sync_q[NUM_PINS+2];

    oe_power_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pdn_n_s (pdn_s),
        .state   (pstate)
    );

    assign run    = (pstate == ST_ON);
    assign pll_on = run;

    oe_pair_gate u_gate (
        .run     (run),
        .pin_s   (pin_s),
        .pair_en (en_q),
        .drv_p   (drv_p),
        .drv_n   (drv_n)
    );

    assign pll_bypass = ~byp_s | ~pll_sel_q;
    assign hi_bw      = ~bw_s  | ~lowbw_q;
    assign pin_status = pin_s;

    // R6
    off_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |-> (drv_p == '0 && drv_n == '0));
    // R1
    legs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_p == drv_n);
    // R2
    grp_lo_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_status[0] |-> (drv_p[4:0] == '0));
    // R2
    grp_hi_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_status[12] |-> (drv_p[17:16] == '0));
    // R3
    last_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_status[13] |-> !drv_p[18]);
    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(main_1to1) && $stable(last_1to1)));
endmodule

// File: tb/sim_clk_oe_ctrl.sv
module sim_clk_oe_ctrl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n;
    logic        oe_grp_lo_n, oe_grp_hi_n, oe_last_n;
    logic [10:0] oe_ind_n;
    logic        pwrdn_n, bw_pin_n, byp_pin_n;
    logic        cfg_we;
    logic [18:0] cfg_pair_en;
    logic        cfg_pll_sel_d, cfg_lowbw_d, cfg_main_1to1_d, cfg_last_1to1_d;
    logic [18:0] drv_p, drv_n;
    logic        pll_bypass, hi_bw, pll_on, main_1to1, last_1to1;
    logic [13:0] pin_status;

    clk_oe_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .oe_grp_lo_n(oe_grp_lo_n), .oe_ind_n(oe_ind_n),
        .oe_grp_hi_n(oe_grp_hi_n), .oe_last_n(oe_last_n),
        .pwrdn_n(pwrdn_n), .bw_pin_n(bw_pin_n), .byp_pin_n(byp_pin_n),
        .cfg_we(cfg_we), .cfg_pair_en(cfg_pair_en),
        .cfg_pll_sel_d(cfg_pll_sel_d), .cfg_lowbw_d(cfg_lowbw_d),
        .cfg_main_1to1_d(cfg_main_1to1_d), .cfg_last_1to1_d(cfg_last_1to1_d),
        .drv_p(drv_p), .drv_n(drv_n), .pll_bypass(pll_bypass), .hi_bw(hi_bw),
        .pll_on(pll_on), .main_1to1(main_1to1), .last_1to1(last_1to1),
        .pin_status(pin_status)
    );

    // ---------------- behavioural reference model ----------------
    logic [13:0] pin_hist [2];     // [0] newest sample, [1] older
    logic        pdn_hist [2];
    logic        bw_hist  [2];
    logic        byp_hist [2];
    logic        m_on;
    logic [18:0] m_en;
    logic        m_pll, m_lbw, m_main, m_last;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_hist[0] <= '1; pin_hist[1] <= '1;
            pdn_hist[0] <= 1;  pdn_hist[1] <= 1;
            bw_hist[0]  <= 1;  bw_hist[1]  <= 1;
            byp_hist[0] <= 1;  byp_hist[1] <= 1;
            m_on <= 0; m_en <= '1;
            m_pll <= 1; m_lbw <= 1; m_main <= 1; m_last <= 1;
        end else begin
            pin_hist[1] <= pin_hist[0];
            pin_hist[0] <= {oe_last_n, oe_grp_hi_n, oe_ind_n, oe_grp_lo_n};
            pdn_hist[1] <= pdn_hist[0]; pdn_hist[0] <= pwrdn_n;
            bw_hist[1]  <= bw_hist[0];  bw_hist[0]  <= bw_pin_n;
            byp_hist[1] <= byp_hist[0]; byp_hist[0] <= byp_pin_n;
            m_on <= pdn_hist[1];
            if (cfg_we) begin
                m_en <= cfg_pair_en; m_pll <= cfg_pll_sel_d; m_lbw <= cfg_lowbw_d;
                m_main <= cfg_main_1to1_d; m_last <= cfg_last_1to1_d;
            end
        end
    end

    integer vectors = 0, miscompares = 0, cycles = 0;
    string  phase = "reset R7";

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s (%s, phase %s): actual %h expected %h",
                     req, what, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [18:0] e_drv;
        integer pin;
        cycles++;
        for (int i = 0; i < 19; i++) begin
            if (i < 5)       pin = 0;
            else if (i < 16) pin = i - 4;
            else if (i < 18) pin = 12;
            else             pin = 13;
            e_drv[i] = m_on && (pin_hist[1][pin] == 1'b0) && m_en[i];
        end
        cmp("R1", "drv_p", {13'd0, drv_p}, {13'd0, e_drv});
        cmp("R1", "drv_n", {13'd0, drv_n}, {13'd0, e_drv});
        cmp("R6", "pll_on", {31'd0, pll_on}, {31'd0, m_on});
        cmp("R5", "pll_bypass", {31'd0, pll_bypass},
            {31'd0, (!byp_hist[1]) || (!m_pll)});
        cmp("R4", "hi_bw", {31'd0, hi_bw}, {31'd0, (!bw_hist[1]) || (!m_lbw)});
        cmp("R7", "ratio", {30'd0, main_1to1, last_1to1}, {30'd0, m_main, m_last});
        cmp("R8", "pin_status", {18'd0, pin_status}, {18'd0, pin_hist[1]});
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_pins(input logic [13:0] p);
        {oe_last_n, oe_grp_hi_n, oe_ind_n, oe_grp_lo_n} = p;
    endtask

    task automatic write_cfg(input logic [18:0] en, input logic pll,
                             input logic lbw, input logic mr, input logic lr);
        cfg_pair_en = en; cfg_pll_sel_d = pll; cfg_lowbw_d = lbw;
        cfg_main_1to1_d = mr; cfg_last_1to1_d = lr;
        cfg_we = 1; tick(1); cfg_we = 0;
    endtask

    initial begin
        rst_n = 0;
        set_pins('0); pwrdn_n = 1; bw_pin_n = 1; byp_pin_n = 1;
        cfg_we = 0; cfg_pair_en = '0;
        cfg_pll_sel_d = 0; cfg_lowbw_d = 0; cfg_main_1to1_d = 0; cfg_last_1to1_d = 0;
        tick(3);                               // reset values checked (R7, R8)
        rst_n = 1;
        phase = "R6 wake"; tick(4);
        phase = "R2 R3 single pin walk";
        for (int k = 0; k < 14; k++) begin
            set_pins(14'(1) << k); tick(4);
        end
        set_pins('0);
        phase = "R7 no write"; cfg_pair_en = '0; cfg_main_1to1_d = 0; tick(3);
        phase = "R2 per-pair disable in groups";
        write_cfg(19'h7FFFF & ~19'h00004, 1, 1, 1, 1); tick(3);
        write_cfg(19'h7FFFF & ~19'h20000, 1, 1, 0, 1); tick(3);
        write_cfg(19'h7FFFF & ~19'h40000, 1, 1, 1, 0); tick(3);
        write_cfg('1, 1, 1, 1, 1); tick(2);
        phase = "R4 R5 override combos";
        for (int c = 0; c < 4; c++) begin
            bw_pin_n = c[0]; byp_pin_n = c[0];
            write_cfg('1, c[1], c[1], 1, 1); tick(3);
            bw_pin_n = c[1]; byp_pin_n = ~c[0];
            write_cfg('1, c[0], ~c[1], 1, 1); tick(3);
        end
        bw_pin_n = 1; byp_pin_n = 1; write_cfg('1, 1, 1, 1, 1);
        phase = "R6 power-down pulse";
        pwrdn_n = 0; tick(5); pwrdn_n = 1; tick(5);
        pwrdn_n = 0; tick(1); pwrdn_n = 1; tick(5);
        phase = "R9 random traffic";
        for (int n = 0; n < 400; n++) begin
            set_pins(14'($urandom));
            pwrdn_n   = ($urandom % 8) != 0;
            bw_pin_n  = 1'($urandom);
            byp_pin_n = 1'($urandom);
            cfg_pair_en = 19'($urandom); cfg_pll_sel_d = 1'($urandom);
            cfg_lowbw_d = 1'($urandom); cfg_main_1to1_d = 1'($urandom);
            cfg_last_1to1_d = 1'($urandom);
            cfg_we = ($urandom % 4) == 0;
            tick(1);
        end
        cfg_we = 0; tick(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule